// File: doc/BRIEF.md
# Stack Processor Call/Return Sequencer

This unit drives instruction issue for a small stack machine. Each 32-bit instruction word carries four 8-bit opcodes. The sequencer hands one opcode per cycle to the execute stage, lowest byte first. It owns the word program counter and a return-address stack.

A call takes a single cycle, and the callee's first opcode issues on the next cycle, with no delay slot. Any non-call opcode with its top bit set also performs a return. The opcode itself issues normally, and the caller resumes on the following cycle, so the return adds no cycles.

The sixteen most recent return addresses are kept on chip. When the stack is full and another call arrives, the oldest entry is spilled, one word at a time, to a memory-side LIFO. When the stack is empty and a return arrives, the newest spilled entry is filled back. In both cases issue stalls until the memory side acknowledges. The instruction memory read port is combinational: the word at `imem_addr` must be present on `imem_rdata` in the same cycle.

Top module: `call_seq`

## Requirements
- R1: While reset is asserted, and until the internal synchronized reset releases, `issue_valid`, `spill_req` and `fill_req` are 0 and `imem_addr` is 0. The first issue is byte [7:0] of word 0.
- R2: Ordinary opcodes issue one per cycle from byte lanes [7:0], [15:8], [23:16] and [31:24], in that order. After lane [31:24], `imem_addr` advances by one word.
- R3: Opcode 8'h01 in lane [7:0] is a call. It issues in one cycle, and on the next cycle `imem_addr` equals bits [31:8] of that word, with lane [7:0] of the target issuing.
- R4: A call saves the address of the word after the one holding it. That is the address a later return resumes at.
- R5: A non-call opcode with bit 7 set issues and also returns. On the next cycle `imem_addr` is the saved address and lane [7:0] issues.
- R6: Opcode 8'h01 in lanes [15:8], [23:16] or [31:24] is an ordinary opcode and does not redirect fetch.
- R7: The on-chip stack holds 16 entries. A call made while it is full raises `spill_req` with `issue_valid` low and `imem_addr` held, until `mem_ack`. During this wait, `spill_data` is the oldest entry and `ras_mem_addr` is the count of spilled entries.
- R8: A return made while the on-chip stack is empty, with entries spilled, raises `fill_req` with `issue_valid` low until `mem_ack`. During this wait, `ras_mem_addr` is the spilled count minus one. After the acknowledge the return issues and resumes at `fill_data`.
- R9: A return with no entry on chip or in memory issues, raises no fill, and resumes at word 0, lane [7:0].
- R10: `spill_req` and `fill_req` are never high together. Spilled entries are written at memory addresses 0, 1, 2, … in oldest-first order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| imem_addr | output | AW | Word address of the instruction word being issued from |
| imem_rdata | input | 32 | Instruction word at `imem_addr` (combinational read) |
| issue_valid | output | 1 | An opcode issues this cycle |
| issue_op | output | 8 | Opcode issued |
| issue_imm | output | 24 | Upper three bytes of the current word (call target) |
| spill_req | output | 1 | Request to write the oldest return entry to memory |
| fill_req | output | 1 | Request to read the newest spilled entry from memory |
| ras_mem_addr | output | MW | Return-stack memory address for spill or fill |
| spill_data | output | AW | Return address being spilled |
| fill_data | input | AW | Return address read back on fill |
| mem_ack | input | 1 | Completes the pending spill or fill this cycle |

## Verification
Two events share a cycle in this block: issuing an arithmetic opcode and performing the return folded into it. A second overlap occurs when a call that finds the stack full waits on the spill before it can push. The bench runs a trace in which a marked opcode is followed at once by the caller's next word. Any extra cycle or missed return shows up as a wrong address/opcode pair in the cycle-by-cycle table. Deep recursion chains fill the stack past its limit and then unwind through marked opcodes. The bench judges spill and fill by the stall length, the memory address, the data, and the word that issues right after the acknowledge.

// File: rtl/stkseq_pkg.sv
package stkseq_pkg;
  localparam logic [7:0] OP_CALL = 8'h01;
  localparam int         RET_BIT = 7;
  localparam int         LANES   = 4;
endpackage

// File: rtl/seq_slot_pick.sv
module seq_slot_pick
  import stkseq_pkg::*;
(
  input  logic [31:0] word,
  input  logic [1:0]  slot,
  output logic [7:0]  op,
  output logic [23:0] imm,
  output logic        is_call,
  output logic        is_ret
);
  logic [7:0] lane [LANES];

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign lane[g] = word[8*g +: 8];
  end

  always_comb begin
    op      = lane[slot];
    imm     = word[31:8];
    is_call = (slot == 2'd0) && (op == OP_CALL);
    is_ret  = op[RET_BIT] && !is_call;
  end
endmodule

// File: rtl/ret_cache.sv
module ret_cache #(
  parameter int DEPTH = 16,
  parameter int AW    = 24
) (
  input  logic          clk,
  input  logic          rstn,
  input  logic          push,
  input  logic          pop,
  input  logic          drop_old,
  input  logic [AW-1:0] push_data,
  output logic [AW-1:0] top_data,
  output logic [AW-1:0] old_data,
  output logic          full,
  output logic          empty
);
  localparam int IW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);

  logic [AW-1:0] ent [DEPTH];
  logic [IW-1:0] tp_q, tp_d, old_ix;
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    tp_d  = tp_q;
    cnt_d = cnt_q;
    if (push) begin
      tp_d  = tp_q + IW'(1);
      cnt_d = cnt_q + CW'(1);
    end else if (pop) begin
      tp_d  = tp_q - IW'(1);
      cnt_d = cnt_q - CW'(1);
    end else if (drop_old) begin
      cnt_d = cnt_q - CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rstn) begin
    if (!rstn) begin
      tp_q  <= '0;
      cnt_q <= '0;
    end else begin
      tp_q  <= tp_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push) ent[tp_d] <= push_data;
  end

  assign old_ix   = tp_q - IW'(cnt_q - CW'(1));
  assign top_data = ent[tp_q];
  assign old_data = ent[old_ix];
  assign full     = (cnt_q == CW'(DEPTH));
  assign empty    = (cnt_q == '0);

  // R7
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rstn)
    push |-> !full);
  // R8
  no_underflow_chk: assert property (@(posedge clk) disable iff (!rstn)
    (pop || drop_old) |-> !empty);
endmodule

// File: rtl/call_seq.sv
module call_seq
  import stkseq_pkg::*;
#(
  parameter int AW    = 24,
  parameter int DEPTH = 16,
  parameter int MW    = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic [AW-1:0] imem_addr,
  input  logic [31:0]   imem_rdata,
  output logic          issue_valid,
  output logic [7:0]    issue_op,
  output logic [23:0]   issue_imm,
  output logic          spill_req,
  output logic          fill_req,
  output logic [MW-1:0] ras_mem_addr,
  output logic [AW-1:0] spill_data,
  input  logic [AW-1:0] fill_data,
  input  logic          mem_ack
);
  logic [1:0]    rsync_q;
  logic          rstn_i;
  logic [AW-1:0] pc_q, pc_d;
  logic [1:0]    slot_q, slot_d;
  logic [MW-1:0] mcnt_q, mcnt_d;
  logic          is_call, is_ret;
  logic          full, empty;
  logic [AW-1:0] top_data, old_data;
  logic          stall, pc_en;
  logic          push, pop, spill_ok, fill_ok;
  logic [AW-1:0] push_data;

  // reset: asserted asynchronously, released after two edges
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rstn_i = rsync_q[1];

  seq_slot_pick u_pick (
    .word    (imem_rdata),
    .slot    (slot_q),
    .op      (issue_op),
    .imm     (issue_imm),
    .is_call (is_call),
    .is_ret  (is_ret)
  );

  ret_cache #(.DEPTH(DEPTH), .AW(AW)) u_cache (
    .clk       (clk),
    .rstn      (rstn_i),
    .push      (push),
    .pop       (pop),
    .drop_old  (spill_ok),
    .push_data (push_data),
    .top_data  (top_data),
    .old_data  (old_data),
    .full      (full),
    .empty     (empty)
  );

  always_comb begin
    spill_req    = rstn_i && is_call && full;
    fill_req     = rstn_i && is_ret && empty && (mcnt_q != '0);
    stall        = spill_req || fill_req;
    issue_valid  = rstn_i && !stall;
    pc_en        = issue_valid;
    spill_ok     = spill_req && mem_ack;
    fill_ok      = fill_req && mem_ack;
    push         = (issue_valid && is_call) || fill_ok;
    pop          = issue_valid && is_ret && !empty;
    push_data    = fill_ok ? fill_data : pc_q + AW'(1);
    spill_data   = old_data;
    ras_mem_addr = spill_req ? mcnt_q : mcnt_q - MW'(1);
    imem_addr    = pc_q;
  end

  always_comb begin
    pc_d   = pc_q;
    slot_d = slot_q;
    if (pc_en) begin
      if (is_call) begin
        pc_d   = AW'(issue_imm);
        slot_d = 2'd0;
      end else if (is_ret) begin
        pc_d   = empty ? '0 : top_data;
        slot_d = 2'd0;
      end else if (slot_q == 2'd3) begin
        pc_d   = pc_q + AW'(1);
        slot_d = 2'd0;
      end else begin
        slot_d = slot_q + 2'd1;
      end
    end
    mcnt_d = mcnt_q;
    if (spill_ok)     mcnt_d = mcnt_q + MW'(1);
    else if (fill_ok) mcnt_d = mcnt_q - MW'(1);
  end

  always_ff @(posedge clk or negedge rstn_i) begin
    if (!rstn_i) begin
      pc_q   <= '0;
      slot_q <= 2'd0;
      mcnt_q <= '0;
    end else begin
      pc_q   <= pc_d;
      slot_q <= slot_d;
      mcnt_q <= mcnt_d;
    end
  end

  // R10
  spill_fill_excl_chk: assert property (@(posedge clk) disable iff (!rstn_i)
    !(spill_req && fill_req));
  // R3
  call_target_chk: assert property (@(posedge clk) disable iff (!rstn_i)
    (issue_valid && is_call) |=> (imem_addr == AW'($past(issue_imm))));
  // R7
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rstn_i)
    (stall && !mem_ack) |=> ($stable(imem_addr) && !issue_valid));
  // R5
  ret_resume_chk: assert property (@(posedge clk) disable iff (!rstn_i)
    (issue_valid && is_ret && !empty) |=> (imem_addr == $past(top_data)));
endmodule

// File: tb/call_seq_test.sv
module call_seq_test;
  localparam int AW = 24;
  localparam int MW = 16;

  logic          clk;
  logic          rst_n;
  logic [AW-1:0] imem_addr;
  logic [31:0]   imem_rdata;
  logic          issue_valid;
  logic [7:0]    issue_op;
  logic [23:0]   issue_imm;
  logic          spill_req, fill_req;
  logic [MW-1:0] ras_mem_addr;
  logic [AW-1:0] spill_data, fill_data;
  logic          mem_ack;

  logic [31:0]   imem [256];
  logic [AW-1:0] rmem [16];
  logic          ack_en;
  int            errors, checks, cyc;

  call_seq uut (
    .clk(clk), .rst_n(rst_n), .imem_addr(imem_addr), .imem_rdata(imem_rdata),
    .issue_valid(issue_valid), .issue_op(issue_op), .issue_imm(issue_imm),
    .spill_req(spill_req), .fill_req(fill_req), .ras_mem_addr(ras_mem_addr),
    .spill_data(spill_data), .fill_data(fill_data), .mem_ack(mem_ack)
  );

  assign imem_rdata = imem[imem_addr[7:0]];
  assign fill_data  = rmem[ras_mem_addr[3:0]];

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // trace of {word address[23:0], opcode} per issuing cycle
  localparam logic [31:0] TRACE [12] = '{
    32'h00000010, 32'h00000011, 32'h00000012, 32'h00000013,
    32'h00000101, 32'h00002021, 32'h000020A2, 32'h00000214,
    32'h00000201, 32'h00000215, 32'h00000216, 32'h00000330
  };

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // memory-side responder: one-cycle acknowledge, records spills
  always @(negedge clk) begin
    #1;
    if (mem_ack) mem_ack = 1'b0;
    else if ((spill_req || fill_req) && ack_en) begin
      if (spill_req) rmem[ras_mem_addr[3:0]] = spill_data;
      mem_ack = 1'b1;
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=<20000", cyc);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic restart();
    rst_n  = 1'b0;
    ack_en = 1'b0;
    for (int i = 0; i < 256; i++) imem[i] = 32'h0;
    for (int i = 0; i < 16; i++) rmem[i] = '0;
    repeat (2) @(negedge clk);
  endtask

  task automatic go();
    rst_n = 1'b1;
    for (int i = 0; i < 10 && !issue_valid; i++) @(negedge clk);
  endtask

  initial begin
    errors = 0; checks = 0; cyc = 0;
    mem_ack = 1'b0;

    // ---- table walk: R2, R3, R4, R5, R6 ----
    restart();
    imem[0]    = 32'h13121110;
    imem[1]    = 32'h00002001;
    imem[2]    = 32'h16150114;
    imem[3]    = 32'h33323130;
    imem[8'h20] = 32'h0000A221;
    // R1 reset state
    chk(!issue_valid && !spill_req && !fill_req && imem_addr == 0, "R1",
        {issue_valid, spill_req, fill_req, 5'd0, imem_addr}, 32'h0);
    go();
    for (int i = 0; i < 12; i++) begin
      // R2 R3 R4 R5 R6: address and opcode of each issuing cycle
      chk(issue_valid && {imem_addr, issue_op} == TRACE[i], "R2/R3/R4/R5/R6 trace",
          {imem_addr, issue_op}, TRACE[i]);
      @(negedge clk);
    end

    // ---- overflow: R7, R10 ----
    restart();
    imem[0] = 32'h00000001;
    go();
    begin
      int n = 0;
      for (int g = 0; g < 100 && !spill_req; g++) begin
        if (issue_valid) n++;
        @(negedge clk);
      end
      chk(n == 16, "R7 calls before spill", n, 16);
    end
    chk(spill_req && !issue_valid && ras_mem_addr == 0 && spill_data == 1,
        "R7 spill request", {spill_req, issue_valid, ras_mem_addr[5:0], spill_data},
        {2'b10, 6'd0, 24'd1});
    repeat (3) @(negedge clk);
    chk(!issue_valid && spill_req && imem_addr == 0, "R7 stall held",
        {issue_valid, spill_req, imem_addr[7:0]}, 32'h1_00);
    ack_en = 1'b1;
    @(negedge clk);
    ack_en = 1'b0;
    chk(issue_valid && !spill_req && !fill_req, "R7 call after ack R10",
        {issue_valid, spill_req, fill_req}, 3'b100);
    @(negedge clk);
    chk(spill_req && ras_mem_addr == 1 && spill_data == 1, "R7 second spill",
        {spill_req, ras_mem_addr[6:0], spill_data}, {1'b1, 7'd1, 24'd1});

    // ---- underflow: R8, R10 ----
    restart();
    for (int k = 0; k < 20; k++) begin
      imem[2*k]   = {24'(2*k + 2), 8'h01};
      imem[2*k+1] = 32'h80808080;
    end
    imem[40] = 32'h80808080;
    ack_en = 1'b1;
    go();
    begin
      int n = 0;
      for (int g = 0; g < 300 && !fill_req; g++) begin
        if (issue_valid && issue_op == 8'h80) n++;
        @(negedge clk);
      end
      chk(n == 16, "R8 returns before fill", n, 16);
    end
    chk(rmem[0] == 1 && rmem[1] == 3 && rmem[2] == 5 && rmem[3] == 7, "R10 spill order",
        {rmem[0][7:0], rmem[1][7:0], rmem[2][7:0], rmem[3][7:0]}, 32'h01030507);
    chk(fill_req && !issue_valid && ras_mem_addr == 3 && imem_addr == 9, "R8 fill request",
        {fill_req, issue_valid, ras_mem_addr[5:0], imem_addr}, {2'b10, 6'd3, 24'd9});
    @(negedge clk);
    chk(issue_valid && issue_op == 8'h80 && !fill_req, "R8 return after fill",
        {issue_valid, fill_req, issue_op}, {2'b10, 8'h80});
    @(negedge clk);
    chk(imem_addr == 7, "R8 resume at filled address", imem_addr, 7);

    // ---- empty return: R9 ----
    restart();
    imem[0] = 32'h00000080;
    imem[1] = 32'h00000055;
    go();
    chk(issue_valid && issue_op == 8'h80 && !fill_req, "R9 issue",
        {issue_valid, fill_req, issue_op}, {2'b10, 8'h80});
    @(negedge clk);
    chk(imem_addr == 0 && issue_op == 8'h80 && !fill_req, "R9 resume word 0",
        {fill_req, imem_addr[7:0], issue_op}, {1'b0, 8'h00, 8'h80});

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule